// File: doc/BRIEF.md
# Edge-Triggered Preset Event Counter

This block counts events that arrive as level conditions. It watches a count-up condition and a count-down condition, and it changes its count only on the cycle where a condition has gone from false to true. A condition that stays true adds nothing more. The count is compared against a preset value to produce a done flag. The done flag can drive the condition input of a second counter, so counters can be cascaded.

A two-bit mode input selects how the block behaves. Up mode counts count-up events. Down mode counts count-down events towards zero. Up/down mode counts both kinds. The clear/load condition either zeroes the count or loads the preset, depending on the mode. The rule that sets the done flag also follows the mode. The count is 16 bits wide by default. It stops at zero and at its maximum value instead of wrapping.

Top module: `edge_preset_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0. A condition input that is held high through the release of reset produces no count on the first cycles after release.
- R2: The count changes only on a clock edge where a condition input is high and was low at the previous clock edge, or where `clr_ld_i` is high. A held level never counts twice.
- R3: Up mode (`mode_i` = 0): a count-up event adds one and count-down events are ignored. `done_o` is high exactly when the count equals `preset_i`.
- R4: Down mode (`mode_i` = 1): a count-down event subtracts one and count-up events are ignored. `done_o` is high exactly when the count is 0.
- R5: Up/down mode (`mode_i` = 2, and 3 behaves the same): count-up events add one and count-down events subtract one. `done_o` is high exactly when the count is greater than or equal to `preset_i`.
- R6: In up/down mode, a count-up event and a count-down event on the same clock edge leave the count unchanged.
- R7: `clr_ld_i` high at a clock edge sets the count to 0 in up and up/down modes. In down mode it sets the count to `preset_i`.
- R8: `clr_ld_i` takes priority over any counting event on the same clock edge.
- R9: The count saturates. It stays at 0 on a decrement and stays at 65535 (all ones) on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_up_i | input | 1 | Count-up condition level |
| cnt_dn_i | input | 1 | Count-down condition level |
| clr_ld_i | input | 1 | Clear (up, up/down) or load preset (down), level |
| mode_i | input | 2 | 0 up, 1 down, 2 or 3 up/down |
| preset_i | input | 16 | Preset compared against or loaded |
| count_o | output | 16 | Current count |
| done_o | output | 1 | Mode-dependent compare result |

## Verification
A stale edge register shows up at the ports as a count that steps one clock after a condition has only stayed high, or as a step that is missing on a real rising edge. Either error is visible on `count_o` at the first clock edge after the stimulus. A wrong count or a wrong saturation decision is held in the count register, so it stays on `count_o` and goes on to bend `done_o` for every later cycle until the next clear or load. The done rule is combinational from the count, the mode and the preset. A wrong rule therefore shows in the same cycle that the mode or the preset is switched.

// File: rtl/epc_pkg.sv
// Package: shared types for the edge-triggered preset event counter.
// Assumes: mode encoding is fixed as below; value 3 is an alias of up/down.
package epc_pkg;

    typedef enum logic [1:0] {
        MODE_UP       = 2'd0,
        MODE_DOWN     = 2'd1,
        MODE_UPDN     = 2'd2,
        MODE_UPDN_ALT = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/edge_rise.sv
// Module: edge_rise
// Registers the previous level of N condition inputs and flags false-to-true
// transitions. Assumes: inputs are synchronous to clk. During reset the
// registers follow the live level, so a level held across reset release
// produces no rise.
module edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Purpose: remember last cycle's level of this condition.
        always_ff @(posedge clk) begin
            prev_q[g] <= level_i[g];
        end

        // Purpose: a rise is high now, low at the previous edge, out of reset.
        always_comb begin
            rise_o[g] = rst_n & level_i[g] & ~prev_q[g];
        end
    end

endmodule

// File: rtl/count_step.sv
// Module: count_step
// Holds the count register and applies clear/load, increment and decrement
// according to the mode. Assumes: rise inputs are one-cycle pulses from an
// edge detector. Saturates at zero and at all ones.
module count_step
    import epc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_up_i,
    input  logic         rise_dn_i,
    input  logic         clr_ld_i,
    input  cnt_mode_e    mode_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    logic [W-1:0] count_q;
    logic [W-1:0] count_d;
    logic         can_inc;
    logic         can_dec;

    // Purpose: headroom tests used for saturation.
    always_comb begin
        can_inc = (count_q != CNT_MAX);
        can_dec = (count_q != CNT_ZERO);
    end

    // Purpose: next count; clear/load first, then the mode's counting rule.
    always_comb begin
        count_d = count_q;
        if (clr_ld_i) begin
            count_d = (mode_i == MODE_DOWN) ? preset_i : CNT_ZERO;
        end else begin
            unique case (mode_i)
                MODE_UP: begin
                    if (rise_up_i && can_inc) count_d = count_q + CNT_ONE;
                end
                MODE_DOWN: begin
                    if (rise_dn_i && can_dec) count_d = count_q - CNT_ONE;
                end
                default: begin
                    if (rise_up_i && !rise_dn_i && can_inc)
                        count_d = count_q + CNT_ONE;
                    else if (rise_dn_i && !rise_up_i && can_dec)
                        count_d = count_q - CNT_ONE;
                end
            endcase
        end
    end

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= CNT_ZERO;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

endmodule

// File: rtl/done_rule.sv
// Module: done_rule
// Combinational done flag: the compare rule is chosen by the mode.
// Assumes: count and preset are unsigned of equal width.
module done_rule
    import epc_pkg::*;
#(
    parameter int W = 16
) (
    input  cnt_mode_e    mode_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] preset_i,
    output logic         done_o
);

    // Purpose: select equal-to-preset, at-zero, or at-least-preset.
    always_comb begin
        unique case (mode_i)
            MODE_UP:   done_o = (count_i == preset_i);
            MODE_DOWN: done_o = (count_i == '0);
            default:   done_o = (count_i >= preset_i);
        endcase
    end

endmodule

// File: rtl/edge_preset_counter.sv
// Module: edge_preset_counter (top)
// Counts rising transitions of level conditions in up, down or up/down mode
// and flags completion against a preset. Assumes: all inputs synchronous to
// clk; reset is synchronous and active low.
module edge_preset_counter
    import epc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_up_i,
    input  logic             cnt_dn_i,
    input  logic             clr_ld_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);

    localparam int N_COND = 2;

    cnt_mode_e         mode;
    logic [N_COND-1:0] rise;
    logic [CNT_W-1:0]  count;

    // Purpose: view the raw mode bits as the shared enum.
    always_comb begin
        mode = cnt_mode_e'(mode_i);
    end

    edge_rise #(.N(N_COND)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({cnt_dn_i, cnt_up_i}),
        .rise_o  (rise)
    );

    count_step #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_up_i (rise[0]),
        .rise_dn_i (rise[1]),
        .clr_ld_i  (clr_ld_i),
        .mode_i    (mode),
        .preset_i  (preset_i),
        .count_o   (count)
    );

    done_rule #(.W(CNT_W)) u_done (
        .mode_i   (mode),
        .count_i  (count),
        .preset_i (preset_i),
        .done_o   (done_o)
    );

    assign count_o = count;

endmodule

// File: rtl/edge_preset_counter_chk.sv
// Module: edge_preset_counter_chk
// Port-level properties of the counter, bound to the top module.
// Assumes: mode encoding 0 up, 1 down, 2/3 up/down.
module edge_preset_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_up_i,
    input logic             cnt_dn_i,
    input logic             clr_ld_i,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] preset_i,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    // R1: reset drives the count to zero.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> count_o == '0);

    // R2: no rising condition and no clear/load -> count holds.
    assert_hold_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_ld_i && !(cnt_up_i && !$past(cnt_up_i)) && !(cnt_dn_i && !$past(cnt_dn_i)))
        |=> $stable(count_o));

    // R3: up-mode done rule.
    assert_done_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |-> (done_o == (count_o == preset_i)));

    // R4: down-mode done rule.
    assert_done_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1) |-> (done_o == (count_o == '0)));

    // R5: up/down-mode done rule.
    assert_done_updn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1]) |-> (done_o == (count_o >= preset_i)));

    // R6: simultaneous events in up/down mode leave the count alone.
    assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && !clr_ld_i && cnt_up_i && !$past(cnt_up_i)
         && cnt_dn_i && !$past(cnt_dn_i)) |=> $stable(count_o));

    // R7/R8: load in down mode takes the preset regardless of edges.
    assert_load_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ld_i && mode_i == 2'd1) |=> count_o == $past(preset_i));

    // R7/R8: clear in other modes gives zero regardless of edges.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ld_i && mode_i != 2'd1) |=> count_o == '0);

    // R9: no wrap from all ones to zero.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == ALL_ONES && !clr_ld_i) |=> count_o != '0);

    // R9: no wrap from zero to all ones.
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && !clr_ld_i) |=> count_o != ALL_ONES);

endmodule

bind edge_preset_counter edge_preset_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_up_i (cnt_up_i),
    .cnt_dn_i (cnt_dn_i),
    .clr_ld_i (clr_ld_i),
    .mode_i   (mode_i),
    .preset_i (preset_i),
    .count_o  (count_o),
    .done_o   (done_o)
);

// File: tb/edge_preset_counter_test.sv
// Bench: table-driven walk through the modes, then directed reset and
// saturation cases. Inputs change on the falling edge; results are sampled
// 1 ns after the rising edge that consumes them.
module edge_preset_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up = 1'b0, dn = 1'b0, ld = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] preset = 16'd3;
    logic [15:0] count;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edge_preset_counter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_up_i (up),
        .cnt_dn_i (dn),
        .clr_ld_i (ld),
        .mode_i   (mode),
        .preset_i (preset),
        .count_o  (count),
        .done_o   (done)
    );

    // Vector: {up, dn, ld, mode[1:0], preset[15:0], exp_count[15:0], exp_done}
    localparam int NV = 33;
    localparam logic [37:0] VECS [NV] = '{
        {1'b1,1'b0,1'b0,2'd0,16'd3,16'd1,1'b0},     // R3 first up edge
        {1'b1,1'b0,1'b0,2'd0,16'd3,16'd1,1'b0},     // R2 held high
        {1'b0,1'b0,1'b0,2'd0,16'd3,16'd1,1'b0},     // R2 falling
        {1'b1,1'b0,1'b0,2'd0,16'd3,16'd2,1'b0},     // R3
        {1'b0,1'b0,1'b0,2'd0,16'd3,16'd2,1'b0},
        {1'b1,1'b0,1'b0,2'd0,16'd3,16'd3,1'b1},     // R3 equals preset
        {1'b0,1'b1,1'b0,2'd0,16'd3,16'd3,1'b1},     // R3 down ignored
        {1'b1,1'b0,1'b0,2'd0,16'd3,16'd4,1'b0},     // R3 past preset
        {1'b0,1'b0,1'b1,2'd0,16'd3,16'd0,1'b0},     // R7 clear
        {1'b0,1'b0,1'b0,2'd1,16'd3,16'd0,1'b1},     // R4 zero done
        {1'b0,1'b0,1'b1,2'd1,16'd3,16'd3,1'b0},     // R7 load
        {1'b0,1'b1,1'b0,2'd1,16'd3,16'd2,1'b0},     // R4
        {1'b0,1'b0,1'b0,2'd1,16'd3,16'd2,1'b0},
        {1'b0,1'b1,1'b0,2'd1,16'd3,16'd1,1'b0},     // R4
        {1'b0,1'b0,1'b0,2'd1,16'd3,16'd1,1'b0},
        {1'b0,1'b1,1'b0,2'd1,16'd3,16'd0,1'b1},     // R4 reaches zero
        {1'b0,1'b0,1'b0,2'd1,16'd3,16'd0,1'b1},
        {1'b0,1'b1,1'b0,2'd1,16'd3,16'd0,1'b1},     // R9 hold at zero
        {1'b1,1'b0,1'b0,2'd1,16'd3,16'd0,1'b1},     // R4 up ignored
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd0,1'b0},     // R5
        {1'b1,1'b0,1'b0,2'd2,16'd2,16'd1,1'b0},     // R5 up
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd1,1'b0},
        {1'b1,1'b0,1'b0,2'd2,16'd2,16'd2,1'b1},     // R5 at preset
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd2,1'b1},
        {1'b1,1'b1,1'b0,2'd2,16'd2,16'd2,1'b1},     // R6 both edges
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd2,1'b1},
        {1'b0,1'b1,1'b0,2'd2,16'd2,16'd1,1'b0},     // R5 down
        {1'b1,1'b0,1'b0,2'd2,16'd2,16'd2,1'b1},     // R5 up
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd2,1'b1},
        {1'b1,1'b0,1'b1,2'd2,16'd2,16'd0,1'b0},     // R8 clear beats up edge
        {1'b0,1'b0,1'b0,2'd2,16'd2,16'd0,1'b0},
        {1'b0,1'b1,1'b1,2'd1,16'd5,16'd5,1'b0},     // R8 load beats down edge
        {1'b0,1'b0,1'b0,2'd1,16'd5,16'd5,1'b0}      // R7
    };

    task automatic check(input string req, input logic [15:0] exp_c, input logic exp_d);
        checks++;
        if (count !== exp_c || done !== exp_d) begin
            errors++;
            $display("FAIL %s: count=%0d done=%b expected count=%0d done=%b",
                     req, count, done, exp_c, exp_d);
        end
    endtask

    task automatic step(input logic u, input logic d, input logic l,
                        input logic [1:0] m, input logic [15:0] p);
        @(negedge clk);
        up = u; dn = d; ld = l; mode = m; preset = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 16'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][37], VECS[i][36], VECS[i][35], VECS[i][34:33], VECS[i][32:17]);
            check($sformatf("table row %0d", i), VECS[i][16:1], VECS[i][0]);
        end

        // R1: reset mid-run with up held high, then release without a false edge.
        @(negedge clk);
        rst_n = 1'b0; up = 1'b1; mode = 2'd0; preset = 16'd3;
        @(posedge clk); #1;
        check("R1 reset clears", 16'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 no false edge at release", 16'd0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 2'd0, 16'd3);
        check("R1 still held", 16'd0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'd3);
        step(1'b1, 1'b0, 1'b0, 2'd0, 16'd3);
        check("R2 fresh edge counts", 16'd1, 1'b0);

        // R9: saturation at all ones.
        step(1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFF);
        check("R7 load all ones", 16'hFFFF, 1'b0);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'hFFFF);
        check("R3 equal at max", 16'hFFFF, 1'b1);
        step(1'b1, 1'b0, 1'b0, 2'd0, 16'hFFFF);
        check("R9 up saturates", 16'hFFFF, 1'b1);
        step(1'b0, 1'b1, 1'b0, 2'd3, 16'd10);
        check("R5 mode 3 decrements", 16'hFFFE, 1'b1);
        step(1'b1, 1'b0, 1'b0, 2'd2, 16'd10);
        check("R5 up to max", 16'hFFFF, 1'b1);
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'd10);
        step(1'b1, 1'b0, 1'b0, 2'd2, 16'd10);
        check("R9 up/down saturates", 16'hFFFF, 1'b1);
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'hFFFF);
        check("R5 at least preset", 16'hFFFF, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule